// File: doc/BRIEF.md
# Graphics Context Swap Sequencer

This block swaps the per-channel state of a graphics engine. It holds a small bank of live state words, a control word, an owner word whose top byte names the channel that currently owns the engine, and a context store with one slot of saved words per channel. When a switch is requested, it stops command fetch and waits for the engine to report idle. If the current context is valid, it copies the live words into the outgoing owner's slot. It then loads the incoming channel's slot, rewrites the control and owner words, and turns command fetch back on.

The live words, the control word and the owner word can be written through a simple write port while no switch is running. All of them can be read back through an index-addressed read port. The save and load steps move one word per clock, so a switch takes a fixed number of cycles that depends only on how many words are saved and how long the engine takes to drain. A request for the channel that already owns the engine only gates and ungates fetch.

Top module: `gfx_ctx_swap`

## Requirements
- R1: After reset, the control word is 0x10000100, the owner word is (NCH-1)<<24, every live word is 0, fetch enable is 1, and busy and done are 0.
- R2: A request is taken only when busy is 0 and the requested id is below NCH. Fetch enable drops, and busy rises, on the clock after a request is taken. Busy stays high and fetch enable stays low until done. Requests made while busy, or for an id of NCH or more, change nothing.
- R3: After a request is taken, the sequencer waits for as many cycles as the idle input is low. No save or load step starts before idle is seen high.
- R4: The current context is valid only when control bit 16 is 1 and the owner id (owner bits 31:24) is below NCH. When the context is valid, every live word is copied into the owner's slot. The control word then becomes 0x10000000 and the owner id becomes NCH-1, with owner bits 23:0 kept. When the context is not valid, no slot is written.
- R5: The load step copies the incoming channel's slot into the live words. The last live word (index NREG-1) keeps only bits 19:0 of its saved value, and its upper 12 bits are cleared.
- R6: At the end of a switch, the control word is 0x10010100 and owner bits 31:24 hold the new id, with owner bits 23:0 unchanged. Fetch enable returns to 1 and done is high for exactly one cycle.
- R7: Before any save, each slot holds 0xfad4ff31 in word 0 and 0 in every other word.
- R8: A request while the context is valid, for the id that already owns the engine, skips both save and load. Done follows 2 cycles after the request is taken when idle is high.
- R9: With idle high, done rises 2*NREG+2 cycles after the request is taken when the context is saved, and NREG+2 cycles when it is not.
- R10: A write with index below NREG sets that live word. Index NREG sets the control word and index NREG+1 sets the owner word. Writes while busy are ignored. Reads use the same index map and return 0 at any other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_req_i | input | 1 | Switch request |
| sw_chan_i | input | 8 | Channel id to switch to |
| eng_idle_i | input | 1 | Engine reports idle |
| fetch_en_o | output | 1 | Command fetch enable |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle pulse when a switch completes |
| st_we_i | input | 1 | State write strobe |
| st_widx_i | input | AW (3) | State write index |
| st_wdata_i | input | 32 | State write data |
| st_ridx_i | input | AW (3) | State read index |
| st_rdata_o | output | 32 | State read data |

## Verification
The first switch after reset runs from an invalid context, so it covers the load-only path and the fresh slot contents. Two channels are then filled with distinct live values and switched between, so a word swapped between slots, a missed save or a missing status mask shows up on read-back. Further patterns cover a same-channel request, a late idle, a request and a write made while busy, an out-of-range id, a cleared valid bit and an owner id of NCH or more. These separate the skip path, the drain wait, the request and write guards, and both no-save conditions. Cycle counts from request to done are checked against the fixed timing in every case.

// File: rtl/gfx_ctx_swap_pkg.sv
package gfx_ctx_swap_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DRAIN,
        PH_SAVE,
        PH_LOAD,
        PH_FIN
    } phase_e;

    localparam logic [31:0] CTRL_RESET  = 32'h1000_0100;
    localparam logic [31:0] CTRL_SAVED  = 32'h1000_0000;
    localparam logic [31:0] CTRL_LOADED = 32'h1001_0100;
    localparam logic [31:0] FRESH_WORD0 = 32'hfad4_ff31;

    localparam int VALID_BIT   = 16;
    localparam int STATUS_KEEP = 20;

endpackage

// File: rtl/gfx_ctx_slots.sv
module gfx_ctx_slots #(
    parameter int          NCH   = 4,
    parameter int          NREG  = 4,
    parameter int          DW    = 32,
    parameter logic [31:0] INIT0 = 32'h0,
    parameter int          CHW   = $clog2(NCH),
    parameter int          IW    = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CHW-1:0] wr_ch,
    input  logic [IW-1:0]  wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [CHW-1:0] rd_ch,
    input  logic [IW-1:0]  rd_idx,
    output logic [DW-1:0]  rd_data
);

    logic [DW-1:0] mem_q [NCH][NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                for (int r = 0; r < NREG; r++) begin
                    mem_q[c][r] <= (r == 0) ? INIT0[DW-1:0] : '0;
                end
            end
        end else if (wr_en) begin
            mem_q[wr_ch][wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_ch][rd_idx];

endmodule

// File: rtl/gfx_ctx_swap.sv
module gfx_ctx_swap
    import gfx_ctx_swap_pkg::*;
#(
    parameter int NCH  = 4,
    parameter int NREG = 4,
    parameter int AW   = $clog2(NREG + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_req_i,
    input  logic [7:0]    sw_chan_i,
    input  logic          eng_idle_i,
    output logic          fetch_en_o,
    output logic          busy_o,
    output logic          done_o,
    input  logic          st_we_i,
    input  logic [AW-1:0] st_widx_i,
    input  logic [31:0]   st_wdata_i,
    input  logic [AW-1:0] st_ridx_i,
    output logic [31:0]   st_rdata_o
);

    localparam int              CHW       = $clog2(NCH);
    localparam int              IW        = $clog2(NREG);
    localparam logic [7:0]      NCH_ID    = 8'(NCH);
    localparam logic [7:0]      LAST_ID   = 8'(NCH - 1);
    localparam logic [IW-1:0]   LAST_IDX  = IW'(NREG - 1);
    localparam logic [AW-1:0]   IDX_CTRL  = AW'(NREG);
    localparam logic [AW-1:0]   IDX_OWNER = AW'(NREG + 1);
    localparam logic [31:0]     KEEP_MASK = (32'h1 << STATUS_KEEP) - 32'h1;

    typedef struct packed {
        phase_e                 ph;
        logic [IW-1:0]          cnt;
        logic [7:0]             src;
        logic [7:0]             tgt;
        logic                   save;
        logic                   skip;
        logic [31:0]            ctrl;
        logic [31:0]            owner;
        logic                   fen;
        logic                   done;
        logic [NREG-1:0][31:0]  live;
    } state_t;

    state_t      q, d;
    logic        slot_we;
    logic [31:0] slot_rdata;
    logic        ctx_valid;

    gfx_ctx_slots #(
        .NCH  (NCH),
        .NREG (NREG),
        .DW   (32),
        .INIT0(FRESH_WORD0)
    ) u_slots (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (slot_we),
        .wr_ch  (q.src[CHW-1:0]),
        .wr_idx (q.cnt),
        .wr_data(q.live[q.cnt]),
        .rd_ch  (q.tgt[CHW-1:0]),
        .rd_idx (q.cnt),
        .rd_data(slot_rdata)
    );

    assign ctx_valid = q.ctrl[VALID_BIT] && (q.owner[31:24] < NCH_ID);

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        slot_we = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (sw_req_i && (sw_chan_i < NCH_ID)) begin
                    d.ph   = PH_DRAIN;
                    d.fen  = 1'b0;
                    d.src  = q.owner[31:24];
                    d.tgt  = sw_chan_i;
                    d.skip = ctx_valid && (q.owner[31:24] == sw_chan_i);
                    d.save = ctx_valid && (q.owner[31:24] != sw_chan_i);
                end
                if (st_we_i) begin
                    if (st_widx_i < IDX_CTRL) begin
                        d.live[st_widx_i[IW-1:0]] = st_wdata_i;
                    end else if (st_widx_i == IDX_CTRL) begin
                        d.ctrl = st_wdata_i;
                    end else if (st_widx_i == IDX_OWNER) begin
                        d.owner = st_wdata_i;
                    end
                end
            end
            PH_DRAIN: begin
                if (eng_idle_i) begin
                    d.cnt = '0;
                    if (q.skip)      d.ph = PH_FIN;
                    else if (q.save) d.ph = PH_SAVE;
                    else             d.ph = PH_LOAD;
                end
            end
            PH_SAVE: begin
                slot_we = 1'b1;
                if (q.cnt == LAST_IDX) begin
                    d.cnt   = '0;
                    d.ph    = PH_LOAD;
                    d.ctrl  = CTRL_SAVED;
                    d.owner = {LAST_ID, q.owner[23:0]};
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            PH_LOAD: begin
                if (q.cnt == LAST_IDX) begin
                    d.live[q.cnt] = slot_rdata & KEEP_MASK;
                    d.ph          = PH_FIN;
                end else begin
                    d.live[q.cnt] = slot_rdata;
                    d.cnt         = q.cnt + 1'b1;
                end
            end
            PH_FIN: begin
                d.ctrl  = CTRL_LOADED;
                d.owner = {q.tgt, q.owner[23:0]};
                d.fen   = 1'b1;
                d.done  = 1'b1;
                d.ph    = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.ph    <= PH_IDLE;
            q.ctrl  <= CTRL_RESET;
            q.owner <= {LAST_ID, 24'h0};
            q.fen   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        st_rdata_o = '0;
        if (st_ridx_i < IDX_CTRL)        st_rdata_o = q.live[st_ridx_i[IW-1:0]];
        else if (st_ridx_i == IDX_CTRL)  st_rdata_o = q.ctrl;
        else if (st_ridx_i == IDX_OWNER) st_rdata_o = q.owner;
    end

    assign fetch_en_o = q.fen;
    assign busy_o     = (q.ph != PH_IDLE);
    assign done_o     = q.done;

    assert_gated_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fetch_en_o);

    assert_bad_id_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sw_req_i && (sw_chan_i >= NCH_ID)) |=> !busy_o);

    assert_drain_waits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_DRAIN && !eng_idle_i) |=> (q.ph == PH_DRAIN));

    assert_saved_words_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_LOAD && $past(q.ph) == PH_SAVE) |->
            (q.ctrl == CTRL_SAVED && q.owner[31:24] == LAST_ID));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fetch_en_o && q.ctrl == CTRL_LOADED && q.owner[31:24] == q.tgt));

    assert_owner_low_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (q.owner[23:0] == $past(q.owner[23:0])));

endmodule

// File: tb/gfx_ctx_swap_bench.sv
module gfx_ctx_swap_bench;

    localparam int NCH  = 4;
    localparam int NREG = 4;
    localparam int AW   = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sw_req_i = 1'b0;
    logic [7:0]    sw_chan_i = '0;
    logic          eng_idle_i = 1'b1;
    logic          fetch_en_o, busy_o, done_o;
    logic          st_we_i = 1'b0;
    logic [AW-1:0] st_widx_i = '0;
    logic [31:0]   st_wdata_i = '0;
    logic [AW-1:0] st_ridx_i = '0;
    logic [31:0]   st_rdata_o;

    always #5 clk = ~clk;

    gfx_ctx_swap #(.NCH(NCH), .NREG(NREG), .AW(AW)) u_gfx_ctx_swap (
        .clk(clk), .rst_n(rst_n), .sw_req_i(sw_req_i), .sw_chan_i(sw_chan_i),
        .eng_idle_i(eng_idle_i), .fetch_en_o(fetch_en_o), .busy_o(busy_o),
        .done_o(done_o), .st_we_i(st_we_i), .st_widx_i(st_widx_i),
        .st_wdata_i(st_wdata_i), .st_ridx_i(st_ridx_i), .st_rdata_o(st_rdata_o)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";

    // behavioural reference
    logic [31:0] m_live [NREG];
    logic [31:0] m_slot [NCH][NREG];
    logic [31:0] m_ctrl, m_owner;
    bit          m_fen, m_done, m_save, m_skip;
    int          m_stage, m_pos, m_from, m_to;

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(int idx);
        if (idx < NREG) return m_live[idx];
        if (idx == NREG) return m_ctrl;
        if (idx == NREG + 1) return m_owner;
        return 32'h0;
    endfunction

    task automatic model_reset();
        foreach (m_live[i]) m_live[i] = 32'h0;
        for (int c = 0; c < NCH; c++)
            for (int r = 0; r < NREG; r++)
                m_slot[c][r] = (r == 0) ? 32'hfad4ff31 : 32'h0;
        m_ctrl  = 32'h10000100;
        m_owner = (NCH - 1) << 24;
        m_fen = 1; m_done = 0; m_stage = 0; m_pos = 0;
    endtask

    task automatic model_step();
        int  own;
        bit  valid;
        if (!rst_n) begin
            model_reset();
            return;
        end
        m_done = 0;
        own = int'(m_owner[31:24]);
        case (m_stage)
            0: begin
                if (sw_req_i && sw_chan_i < NCH) begin
                    valid  = m_ctrl[16] && own < NCH;
                    m_from = own;
                    m_to   = int'(sw_chan_i);
                    m_skip = valid && own == m_to;
                    m_save = valid && own != m_to;
                    m_fen  = 0;
                    m_stage = 1;
                end
                if (st_we_i) begin
                    if (st_widx_i < NREG) m_live[st_widx_i] = st_wdata_i;
                    else if (st_widx_i == NREG) m_ctrl = st_wdata_i;
                    else if (st_widx_i == NREG + 1) m_owner = st_wdata_i;
                end
            end
            1: if (eng_idle_i) begin
                m_pos = 0;
                m_stage = m_skip ? 4 : (m_save ? 2 : 3);
            end
            2: begin
                m_slot[m_from][m_pos] = m_live[m_pos];
                if (m_pos == NREG - 1) begin
                    m_ctrl  = 32'h10000000;
                    m_owner = {8'(NCH - 1), m_owner[23:0]};
                    m_pos = 0; m_stage = 3;
                end else m_pos++;
            end
            3: begin
                m_live[m_pos] = (m_pos == NREG - 1) ? (m_slot[m_to][m_pos] & 32'h000fffff)
                                                    : m_slot[m_to][m_pos];
                if (m_pos == NREG - 1) m_stage = 4; else m_pos++;
            end
            default: begin
                m_ctrl  = 32'h10010100;
                m_owner = {8'(m_to), m_owner[23:0]};
                m_fen = 1; m_done = 1; m_stage = 0;
            end
        endcase
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        check("R2", "fetch_en", 32'(fetch_en_o), 32'(m_fen));
        check("R2", "busy", 32'(busy_o), 32'(m_stage != 0));
        check("R6", "done", 32'(done_o), 32'(m_done));
        check(cur_req, "rdata", st_rdata_o, model_read(int'(st_ridx_i)));
    endtask

    task automatic wr(int idx, logic [31:0] data);
        st_we_i = 1; st_widx_i = AW'(idx); st_wdata_i = data;
        cycle();
        st_we_i = 0;
    endtask

    task automatic rd_check(string req, int idx, logic [31:0] exp);
        st_ridx_i = AW'(idx);
        cycle();
        check(req, "read", st_rdata_o, exp);
    endtask

    task automatic sweep();
        for (int i = 0; i < NREG + 3; i++) begin
            st_ridx_i = AW'(i);
            cycle();
        end
    endtask

    task automatic switch_to(int id, int dly, int exp_n, string req);
        int n;
        eng_idle_i = (dly == 0);
        sw_req_i = 1; sw_chan_i = 8'(id);
        cycle();
        sw_req_i = 0;
        n = 0;
        for (int k = 0; k < dly; k++) begin
            cycle(); n++;
        end
        eng_idle_i = 1;
        while (!done_o && n < 200) begin
            cycle(); n++;
        end
        check(req, "cycles to done", 32'(n), 32'(exp_n));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        cycle(); cycle();
        rst_n = 1;
        // R1 reset state
        cur_req = "R1";
        sweep();
        rd_check("R1", 4, 32'h10000100);
        rd_check("R1", 5, 32'h03000000);

        // R7 first switch from invalid context: load only
        cur_req = "R7";
        switch_to(1, 0, 6, "R9");
        rd_check("R7", 0, 32'hfad4ff31);
        rd_check("R7", 1, 32'h0);
        rd_check("R6", 4, 32'h10010100);
        rd_check("R6", 5, 32'h01000000);

        // R10 fill live words and owner low bits
        cur_req = "R10";
        wr(0, 32'h11111111); wr(1, 32'h22222222);
        wr(2, 32'h33333333); wr(3, 32'hFFFFFFFF);
        wr(5, 32'h01ABCDEF);
        sweep();
        rd_check("R10", 7, 32'h0);

        // R3 late idle, R4 save of channel 1
        cur_req = "R4";
        switch_to(2, 3, 13, "R3");
        rd_check("R6", 5, 32'h02ABCDEF);
        rd_check("R4", 0, 32'hfad4ff31);
        sweep();

        // R5 restore channel 1 with status mask
        cur_req = "R5";
        wr(0, 32'hA5A5A5A5);
        switch_to(1, 0, 10, "R9");
        rd_check("R5", 0, 32'h11111111);
        rd_check("R5", 2, 32'h33333333);
        rd_check("R5", 3, 32'h000FFFFF);

        // R8 same-channel request
        cur_req = "R8";
        switch_to(1, 0, 2, "R8");
        rd_check("R8", 0, 32'h11111111);
        rd_check("R8", 5, 32'h01ABCDEF);

        // R2 bad id ignored
        cur_req = "R2";
        sw_req_i = 1; sw_chan_i = 8'd4;
        cycle();
        sw_req_i = 0;
        cycle();
        check("R2", "busy after bad id", 32'(busy_o), 32'h0);
        check("R2", "fetch after bad id", 32'(fetch_en_o), 32'h1);

        // R2 request and R10 write while busy are ignored
        eng_idle_i = 0;
        sw_req_i = 1; sw_chan_i = 8'd3;
        cycle();
        sw_req_i = 1; sw_chan_i = 8'd0;
        st_we_i = 1; st_widx_i = AW'(5); st_wdata_i = 32'h0;
        cycle();
        sw_req_i = 0; st_we_i = 0;
        eng_idle_i = 1;
        for (int k = 0; k < 40 && !done_o; k++) cycle();
        cycle();
        rd_check("R2", 5, 32'h03ABCDEF);
        rd_check("R10", 0, 32'hfad4ff31);

        // R4 cleared valid bit: no save into slot 3
        cur_req = "R4";
        wr(0, 32'h77777777);
        wr(4, 32'h0);
        switch_to(0, 0, 6, "R4");
        switch_to(3, 0, 10, "R9");
        rd_check("R4", 0, 32'hfad4ff31);

        // R4 owner id out of range: no save
        wr(5, 32'hFF000012);
        switch_to(1, 0, 6, "R4");
        rd_check("R4", 0, 32'h11111111);
        rd_check("R6", 5, 32'h01000012);
        sweep();

        finish_run();
    end

endmodule